// File: doc/BRIEF.md
# Programmable Reload Down-Counter Timer

This block is a single 32-bit down-counting timer channel on a small synchronous register port. Software loads a start value into the count register and, if needed, a second value into the reload register. It then sets the enable bit in the mode register. The counter drops by one on every tick from a free-running prescaler. The prescaler divides the bus clock by 1, 4, 16 or 64, as a 2-bit select field chooses.

When the count reaches zero the block pulses its interrupt output. What follows depends on the reload bit. With the bit set, the count is refilled from the reload register on the next clock and counting goes on. With the bit clear, the timer clears its own enable bit, holds the count at zero and raises a sticky terminal-count flag. Software clears that flag by touching the mode register. A mode bit gates software access to the count and reload registers. Both registers stay writable while the timer runs.

Top module: `rld_timer`

## Requirements
- R1: After a synchronous reset the mode register reads 0, the count and reload registers are 0, and the interrupt output stays low.
- R2: While the enable bit (mode bit 0) is set, the count drops by exactly one per prescaler tick. While it is clear, the count does not change.
- R3: Mode bits 5:4 select the tick rate: 00 gives a tick every clock, 01 every 4 clocks, 10 every 16 clocks and 11 every 64 clocks, taken from a free-running prescaler.
- R4: The interrupt output is high for one clock per terminal count, in the cycle in which the count first reads zero.
- R5: With the reload bit (mode bit 1) clear, reaching zero clears the enable bit, leaves the count at zero and sets the status bit (mode bit 2). Reading the mode register then returns 0x0C for a mode written as 0x09.
- R6: The status bit stays set until the next read or write of the mode register, which clears it. A new terminal count in the same cycle keeps it set.
- R7: With the reload and enable bits set and the count at zero, the next clock copies the reload register into the count. The interrupt period is therefore reload×4^select clocks for selects 01 to 11, and reload+1 clocks for select 00.
- R8: Mode bit 3 gates access. While it is clear, writes to the count and reload registers are ignored and reads of them return 0.
- R9: A software write to the count register takes effect in the same cycle as a coinciding tick, and that tick does not decrement the count.
- R10: A programmed zero is defined. In reload mode with reload value 0, the interrupt fires on every tick. In one-shot mode, enabling with a count of 0 stops the timer at once, sets the status bit and pulses the interrupt once.
- R11: Register addresses: 0 is the mode register, 1 is the count register, 2 is the reload register. Address 3 reads 0 and ignores writes. Read data is 0 unless a read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from current state |
| irq | output | 1 | Terminal-count interrupt pulse |

## Verification
A software write to the count register and a prescaler decrement can land in the same clock. With the divide-by-one select every clock is a tick, so a count write issued while the timer runs in that mode always collides with a decrement. The bench reads the count in the cycle right after the write and expects exactly the written value. In the following cycle it expects one less, which shows that the write won and that decrementing then resumed.

// File: rtl/rld_timer_pkg.sv
package rld_timer_pkg;

    typedef enum logic [1:0] {
        TICK_DIV1  = 2'd0,
        TICK_DIV4  = 2'd1,
        TICK_DIV16 = 2'd2,
        TICK_DIV64 = 2'd3
    } tick_sel_e;

    typedef enum logic [1:0] {
        REG_MODE   = 2'd0,
        REG_COUNT  = 2'd1,
        REG_RELOAD = 2'd2,
        REG_VOID   = 2'd3
    } reg_sel_e;

    // Mode word, MSB first: select[5:4], access[3], done[2], autoload[1], run[0]
    typedef struct packed {
        tick_sel_e sel;
        logic      access;
        logic      done;
        logic      autoload;
        logic      run;
    } mode_t;

    localparam int unsigned MODE_W   = $bits(mode_t);
    localparam int unsigned POS_RUN  = 0;
    localparam int unsigned POS_AUTO = 1;
    localparam int unsigned POS_ACC  = 3;
    localparam int unsigned POS_SELL = 4;
    localparam int unsigned POS_SELH = 5;
    localparam int unsigned N_SEL    = 4;

    function automatic int unsigned sel_shift(input int unsigned step, input int unsigned idx);
        return step * idx;
    endfunction

endpackage

// File: rtl/rld_prescale.sv
module rld_prescale
    import rld_timer_pkg::*;
#(
    parameter int unsigned DIV_STEP = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  tick_sel_e sel_i,
    output logic      tick_o
);
    localparam int unsigned PRE_W = DIV_STEP * (N_SEL - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] sel_mask [N_SEL];

    for (genvar g = 0; g < N_SEL; g++) begin : g_mask
        assign sel_mask[g] = PRE_W'((64'd1 << sel_shift(DIV_STEP, g)) - 64'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + PRE_W'(1);
    end

    always_comb tick_o = ((pre_q & sel_mask[sel_i]) == sel_mask[sel_i]);

endmodule

// File: rtl/rld_count_core.sv
module rld_count_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             auto_i,
    input  logic             tick_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             stop_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             irq_q, irq_d;
    logic             at_zero;

    always_comb begin
        at_zero = (cnt_q == '0);
        cnt_d   = cnt_q;
        irq_d   = 1'b0;
        stop_o  = 1'b0;
        if (cnt_wr_i) begin
            cnt_d = wdata_i;
        end else if (run_i) begin
            if (at_zero) begin
                if (auto_i) begin
                    cnt_d = reload_i;
                    irq_d = tick_i && (reload_i == '0);
                end else begin
                    stop_o = 1'b1;
                    irq_d  = 1'b1;
                end
            end else if (tick_i) begin
                cnt_d = cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    irq_d  = 1'b1;
                    stop_o = !auto_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq_q <= irq_d;
        end
    end

    assign cnt_o = cnt_q;
    assign irq_o = irq_q;

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (cnt_q == '0)); // R4
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (run_i && tick_i && !cnt_wr_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !cnt_wr_i) |=> $stable(cnt_q)); // R2
    AST_REFILL: assert property (@(posedge clk) disable iff (rst)
        (run_i && auto_i && cnt_q == '0 && !cnt_wr_i) |=> (cnt_q == $past(reload_i))); // R7

endmodule

// File: rtl/rld_ctrl_regs.sv
module rld_ctrl_regs
    import rld_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             stop_i,
    output mode_t            mode_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             cnt_wr_o,
    output logic [CNT_W-1:0] rdata_o
);
    mode_t            mode_q;
    logic [CNT_W-1:0] reload_q;
    logic             mode_hit, mode_wr, reload_wr;

    always_comb begin
        mode_hit  = bus_sel && (bus_wr || bus_rd) && (bus_addr == REG_MODE);
        mode_wr   = bus_sel && bus_wr && (bus_addr == REG_MODE);
        cnt_wr_o  = bus_sel && bus_wr && (bus_addr == REG_COUNT) && mode_q.access;
        reload_wr = bus_sel && bus_wr && (bus_addr == REG_RELOAD) && mode_q.access;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            reload_q <= '0;
        end else begin
            if (mode_wr) begin
                mode_q.run      <= bus_wdata[POS_RUN];
                mode_q.autoload <= bus_wdata[POS_AUTO];
                mode_q.access   <= bus_wdata[POS_ACC];
                mode_q.sel      <= tick_sel_e'(bus_wdata[POS_SELH:POS_SELL]);
            end else if (stop_i) begin
                mode_q.run <= 1'b0;
            end
            if (stop_i)        mode_q.done <= 1'b1;
            else if (mode_hit) mode_q.done <= 1'b0;
            if (reload_wr) reload_q <= bus_wdata;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (bus_sel && bus_rd) begin
            case (bus_addr)
                REG_MODE:   rdata_o = CNT_W'(mode_q);
                REG_COUNT:  rdata_o = mode_q.access ? cnt_i : '0;
                REG_RELOAD: rdata_o = mode_q.access ? reload_q : '0;
                default:    rdata_o = '0;
            endcase
        end
    end

    assign mode_o   = mode_q;
    assign reload_o = reload_q;

    AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> mode_q.done); // R6
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (mode_hit && !stop_i) |=> !mode_q.done); // R6
    AST_STOP_RUN: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !mode_wr) |=> !mode_q.run); // R5

endmodule

// File: rtl/rld_timer.sv
module rld_timer
    import rld_timer_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned DIV_STEP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    mode_t            mode;
    logic [CNT_W-1:0] reload_val, cnt_val;
    logic             tick, cnt_wr, stop;

    rld_prescale #(.DIV_STEP(DIV_STEP)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (mode.sel),
        .tick_o (tick)
    );

    rld_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_i     (cnt_val),
        .stop_i    (stop),
        .mode_o    (mode),
        .reload_o  (reload_val),
        .cnt_wr_o  (cnt_wr),
        .rdata_o   (bus_rdata)
    );

    rld_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .run_i    (mode.run),
        .auto_i   (mode.autoload),
        .tick_i   (tick),
        .cnt_wr_i (cnt_wr),
        .wdata_i  (bus_wdata),
        .reload_i (reload_val),
        .cnt_o    (cnt_val),
        .irq_o    (irq),
        .stop_o   (stop)
    );

endmodule

// File: tb/test_rld_timer.sv
module test_rld_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0, fails = 0, cyc = 0;
    int irq_n = 0, irq_last = 0, irq_per = 0;
    bit done = 0;

    typedef struct { logic [31:0] e; string req; } sb_t;
    sb_t sb_q[$];

    rld_timer i_rld_timer (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // irq monitor and read scoreboard, sampled mid-cycle
    always @(negedge clk) begin
        sb_t it;
        #1;
        if (!rst && irq) begin
            if (irq_n > 0) irq_per = cyc - irq_last;
            irq_last = cyc;
            irq_n++;
        end
        if (sel && rd) begin
            if (sb_q.size() == 0) chk("R11 unexpected read", 32'd1, 32'd0);
            else begin
                it = sb_q.pop_front();
                chk(it.req, rdata, it.e);
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; rd = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic read_expect(input logic [1:0] a, input logic [31:0] e, input string req);
        sb_t it;
        it.e = e; it.req = req;
        sb_q.push_back(it);
        sel = 1'b1; rd = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int cw, n0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_expect(2'd0, 32'h0, "R1 mode after reset");
        idle(5);
        chk("R1 no irq after reset", irq_n, 0);

        // R8 gating with access bit clear
        bus_write(2'd1, 32'h55);
        bus_write(2'd2, 32'h66);
        read_expect(2'd1, 32'h0, "R8 count read gated");
        bus_write(2'd0, 32'h08);
        read_expect(2'd1, 32'h0, "R8 count write ignored");
        read_expect(2'd2, 32'h0, "R8 reload write ignored");
        read_expect(2'd3, 32'h0, "R11 void address");
        bus_write(2'd3, 32'hFFFF);
        read_expect(2'd0, 32'h08, "R11 void write no effect");

        // R2 R4 R5 one-shot, divide by one
        bus_write(2'd1, 32'd5);
        n0 = irq_n;
        bus_write(2'd0, 32'h09);
        cw = cyc;
        idle(12);
        chk("R4 irq after five ticks", irq_last - cw, 5);
        chk("R4 single pulse", irq_n - n0, 1);
        read_expect(2'd1, 32'h0, "R5 count held at zero");
        read_expect(2'd0, 32'h0C, "R5 run cleared status set");
        read_expect(2'd0, 32'h08, "R6 status cleared by read");

        // R6 clear by mode write
        bus_write(2'd1, 32'd2);
        bus_write(2'd0, 32'h09);
        idle(8);
        bus_write(2'd0, 32'h08);
        read_expect(2'd0, 32'h08, "R6 status cleared by write");

        // R3 R7 reload period per select
        for (int k = 0; k < 4; k++) begin
            int rv, per;
            rv  = (k == 0) ? 4 : 4 - k;
            per = (k == 0) ? rv + 1 : rv * (1 << (2 * k));
            bus_write(2'd0, 32'h08);
            bus_write(2'd2, rv);
            bus_write(2'd1, rv);
            read_expect(2'd2, rv, "R7 reload readback");
            n0 = irq_n;
            bus_write(2'd0, 32'h0B | (k << 4));
            idle(per * 3 + 10);
            chk("R3 R7 interrupt period", irq_per, per);
            chk("R7 repeated interrupts", (irq_n - n0) >= 2, 1);
        end

        // R2 hold while disabled
        bus_write(2'd0, 32'h08);
        bus_write(2'd1, 32'd77);
        idle(5);
        read_expect(2'd1, 32'd77, "R2 hold when disabled");
        bus_write(2'd0, 32'h00);
        read_expect(2'd1, 32'h0, "R8 count read gated");
        bus_write(2'd1, 32'd9);
        bus_write(2'd0, 32'h08);
        read_expect(2'd1, 32'd77, "R8 gated write ignored");

        // R9 write beats coinciding decrement
        bus_write(2'd2, 32'd1000);
        bus_write(2'd1, 32'd1000);
        bus_write(2'd0, 32'h0B);
        idle(3);
        bus_write(2'd1, 32'd50);
        read_expect(2'd1, 32'd50, "R9 write wins over tick");
        read_expect(2'd1, 32'd49, "R2 decrement resumes");

        // R10 zero reload
        bus_write(2'd0, 32'h08);
        bus_write(2'd2, 32'd0);
        bus_write(2'd1, 32'd0);
        bus_write(2'd0, 32'h0B);
        idle(3);
        n0 = irq_n;
        idle(10);
        chk("R10 irq every tick", irq_n - n0, 10);

        // R10 zero one-shot
        bus_write(2'd0, 32'h08);
        read_expect(2'd0, 32'h08, "R10 mode before start");
        n0 = irq_n;
        bus_write(2'd0, 32'h09);
        idle(5);
        chk("R10 one pulse on zero start", irq_n - n0, 1);
        read_expect(2'd0, 32'h0C, "R10 stopped with status");

        idle(2);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule